// File: doc/BRIEF.md
# Peripheral Reset Control Register Bank

This block holds the reset state of up to ninety-six peripherals and raises a whole-chip software reset request. Three 32-bit reset registers sit behind a plain word-wide register port. Every bit of these registers drives one active-high reset line out of the block for as long as it holds a one. A fourth register accepts a software reset command. When the bit selected by the configured reset number is written as one, the block emits a single-cycle system reset request and then clears that register by itself.

Next to the register port there is a reset-identifier port. Software or a sequencer can name a single reset line there with a packed code and set it, clear it or query it, without touching the other lines held in the same register. An identifier that points outside the three reset registers, or past bit 31, is answered with an error strobe and leaves every register untouched. A register write that lands in the same cycle as a set or clear wins that cycle. The identifier operation is then held back by one cycle, so it cannot overwrite the write or be overwritten by it.

Top module: `rst_bank_top`

## Requirements
- R1: After `rstN` is deasserted, all three reset registers and the software reset register read zero, `periphRst` is all zero and `sysRstReq` is low.
- R2: A write with `busWrEn` to byte offset 0x20, 0x24 or 0x34 loads the full 32-bit word into that register, and the register reads back the same value from the cycle after. `periphRst[31:0]`, `[63:32]` and `[95:64]` mirror the registers at 0x20, 0x24 and 0x34 in that order.
- R3: A read of any offset other than 0x14, 0x20, 0x24 or 0x34 returns zero. A write to such an offset changes no register and no output.
- R4: An identifier `idCode` carries the register offset in bits [15:8] and the bit index in bits [4:0]. `idOp` 2'b00 is a set: when `idAck` is high it forces the addressed bit to one and leaves the other 95 lines as they were.
- R5: `idOp` 2'b01 is a clear: when `idAck` is high it forces the addressed bit to zero and leaves all other lines unchanged.
- R6: `idOp` 2'b10 is a status query: while `idAck` is high, `idStatus` equals the current value of the addressed bit, and no register changes.
- R7: An identifier with an offset other than 0x20, 0x24 or 0x34, with any of bits [7:5] nonzero (a bit index of 32 or more), or with `idOp` 2'b11 is illegal. `idError` is high together with `idAck`, no register changes, and `idStatus` stays low.
- R8: When `busWrEn` and a set or clear request are present in the same cycle, the bus write takes effect and `idAck` is low. With `idValid` held, the identifier operation is accepted in the next free cycle and is applied on top of the written value.
- R9: Writing offset 0x14 with bit (2 + `SW_RST_NUM`) set raises `sysRstReq` for exactly one cycle, starting the cycle after the write. Offset 0x14 then reads zero. A write without that bit raises no request and the value is held and readable.
- R10: With `SW_RST_NUM` outside 1 to 4, `sysRstReq` never rises, whatever is written to offset 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| busAddr | input | ADDR_W | Byte offset for read and write |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| idValid | input | 1 | Identifier request present; held until `idAck` |
| idOp | input | 2 | 00 set, 01 clear, 10 status, 11 illegal |
| idCode | input | ID_W | Packed identifier: offset in [15:8], bit in [4:0] |
| idAck | output | 1 | Request accepted this cycle |
| idError | output | 1 | Accepted request was illegal |
| idStatus | output | 1 | Addressed bit value for a status query |
| periphRst | output | 96 | Active-high peripheral reset lines |
| sysRstReq | output | 1 | One-cycle system reset request |

## Verification
The main instance is built with `SW_RST_NUM` = 3. The trigger is then bit 5, and a write that sets only bit 2 can be shown to leave the request low while the value stays readable. A second instance shares all inputs and uses `SW_RST_NUM` = 0. This puts the out-of-range setting within reach, so the bench can show that the same command word raises nothing there and is never cleared.

// File: rtl/rst_bank_pkg.sv
package rst_bank_pkg;
  localparam int NUM_REGS = 3;
  localparam int DATA_W = 32;
  localparam int BIT_W = $clog2(DATA_W);
  localparam int LINES = NUM_REGS * DATA_W;
  localparam logic [7:0] SW_OFFSET = 8'h14;

  localparam logic [1:0] OP_SET = 2'b00;
  localparam logic [1:0] OP_CLR = 2'b01;
  localparam logic [1:0] OP_QRY = 2'b10;

  // Offset order defines which slice of periphRst a register drives.
  function automatic logic [7:0] regOffset(input int k);
    case (k)
      0: return 8'h20;
      1: return 8'h24;
      default: return 8'h34;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_REGS-1:0] busSel;
    logic                swSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdSw;
    logic [NUM_REGS-1:0] idSel;
    logic                idSet;
    logic                idClr;
    logic                idQuery;
    logic [BIT_W-1:0]    idBit;
  } ctrl_t;
endpackage

// File: rtl/rst_bank_ctrl.sv
module rst_bank_ctrl
  import rst_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              idValid,
  input  logic [1:0]        idOp,
  input  logic [ID_W-1:0]   idCode,
  output ctrl_t             strb,
  output logic              idAck,
  output logic              idError
);
  localparam int OFF_W = ID_W - 8;

  logic [NUM_REGS-1:0] busHit;
  logic [NUM_REGS-1:0] idHit;
  logic [OFF_W-1:0]    idOff;
  logic                legal;
  logic                modOp;
  logic                doOp;

  assign idOff = idCode[ID_W-1:8];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    assign busHit[k] = busAddr == ADDR_W'(regOffset(k));
    assign idHit[k]  = idOff == OFF_W'(regOffset(k));
  end

  assign legal = (|idHit) && (idCode[7:BIT_W] == '0) && (idOp != 2'b11);
  assign modOp = (idOp == OP_SET) || (idOp == OP_CLR);
  assign idAck = idValid && !(busWrEn && modOp);
  assign idError = idAck && !legal;
  assign doOp = idAck && legal;

  always_comb begin
    strb = '0;
    strb.busSel  = busWrEn ? busHit : '0;
    strb.swSel   = busWrEn && (busAddr == ADDR_W'(SW_OFFSET));
    strb.rdSel   = busHit;
    strb.rdSw    = busAddr == ADDR_W'(SW_OFFSET);
    strb.idSel   = doOp ? idHit : '0;
    strb.idSet   = idOp == OP_SET;
    strb.idClr   = idOp == OP_CLR;
    strb.idQuery = doOp && (idOp == OP_QRY);
    strb.idBit   = idCode[BIT_W-1:0];
  end
endmodule

// File: rtl/rst_bank_dp.sv
module rst_bank_dp
  import rst_bank_pkg::*;
#(
  parameter int SW_RST_NUM = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              idStatus,
  output logic [LINES-1:0]  periphRst,
  output logic              sysRstReq
);
  localparam bit SW_VALID = (SW_RST_NUM >= 1) && (SW_RST_NUM <= 4);
  localparam int TRIG_BIT = SW_VALID ? 2 + SW_RST_NUM : 0;

  logic [DATA_W-1:0]   rstReg [NUM_REGS];
  logic [DATA_W-1:0]   swReg;
  logic [NUM_REGS-1:0] bitAt;
  logic                swTrig;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rstReg[k] <= '0;
      else if (strb.busSel[k]) rstReg[k] <= busWrData;
      else if (strb.idSel[k] && strb.idSet) rstReg[k][strb.idBit] <= 1'b1;
      else if (strb.idSel[k] && strb.idClr) rstReg[k][strb.idBit] <= 1'b0;
    end
    assign bitAt[k] = rstReg[k][strb.idBit];
    assign periphRst[k*DATA_W +: DATA_W] = rstReg[k];
  end

  if (SW_VALID) begin : g_sw
    assign swTrig = swReg[TRIG_BIT];
  end else begin : g_nosw
    assign swTrig = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swReg <= '0;
    else if (strb.swSel) swReg <= busWrData;
    else if (swTrig) swReg <= '0;
  end

  assign sysRstReq = swTrig;
  assign idStatus = strb.idQuery && |(strb.idSel & bitAt);

  always_comb begin
    busRdData = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (strb.rdSel[k]) busRdData = busRdData | rstReg[k];
    if (strb.rdSw) busRdData = busRdData | swReg;
  end
endmodule

// File: rtl/rst_bank_top.sv
module rst_bank_top
  import rst_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W = 16,
  parameter int SW_RST_NUM = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              idValid,
  input  logic [1:0]        idOp,
  input  logic [ID_W-1:0]   idCode,
  output logic              idAck,
  output logic              idError,
  output logic              idStatus,
  output logic [95:0]       periphRst,
  output logic              sysRstReq
);
  ctrl_t strb;

  rst_bank_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W)) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .idValid(idValid), .idOp(idOp),
    .idCode(idCode), .strb(strb), .idAck(idAck), .idError(idError)
  );

  rst_bank_dp #(.SW_RST_NUM(SW_RST_NUM)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .idStatus(idStatus), .periphRst(periphRst),
    .sysRstReq(sysRstReq)
  );
endmodule

// File: rtl/rst_bank_chk.sv
module rst_bank_chk
  import rst_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W = 16,
  parameter int SW_RST_NUM = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic              idValid,
  input logic [1:0]        idOp,
  input logic [ID_W-1:0]   idCode,
  input logic              idAck,
  input logic              idError,
  input logic [95:0]       periphRst,
  input logic              sysRstReq
);
  localparam bit SW_VALID = (SW_RST_NUM >= 1) && (SW_RST_NUM <= 4);
  localparam int TRIG_BIT = SW_VALID ? 2 + SW_RST_NUM : 0;

  logic [6:0] flatIdx;
  always_comb begin
    flatIdx = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idCode[ID_W-1:8] == (ID_W-8)'(regOffset(k)))
        flatIdx = 7'(k * 32) + 7'(idCode[4:0]);
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);
  assert_req_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(busWrEn && busAddr == ADDR_W'(SW_OFFSET) && busWrData[TRIG_BIT]));
  assert_no_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !SW_VALID |-> !sysRstReq);
  assert_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idError && !busWrEn) |=> $stable(periphRst));
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && busWrEn && (idOp == OP_SET || idOp == OP_CLR)) |-> !idAck);
  assert_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idAck && !idError && idOp == OP_SET) |=> periphRst[$past(flatIdx)]);
  assert_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (idAck && !idError && idOp == OP_CLR) |=> !periphRst[$past(flatIdx)]);
  assert_query_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idAck && idOp == OP_QRY && !busWrEn) |=> $stable(periphRst));
endmodule

bind rst_bank_top rst_bank_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .SW_RST_NUM(SW_RST_NUM)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .idValid(idValid), .idOp(idOp), .idCode(idCode), .idAck(idAck), .idError(idError),
  .periphRst(periphRst), .sysRstReq(sysRstReq)
);

// File: tb/rst_bank_top_tb_top.sv
`timescale 1ns/1ps
module rst_bank_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic idValid = 1'b0;
  logic [1:0] idOp = '0;
  logic [15:0] idCode = '0;
  logic [31:0] busRdData, rdNoSw;
  logic idAck, idError, idStatus, sysRstReq;
  logic ackNoSw, errNoSw, stNoSw, reqNoSw;
  logic [95:0] periphRst, prNoSw;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rst_bank_top #(.SW_RST_NUM(3)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .idValid(idValid), .idOp(idOp), .idCode(idCode), .idAck(idAck),
    .idError(idError), .idStatus(idStatus), .periphRst(periphRst), .sysRstReq(sysRstReq));

  rst_bank_top #(.SW_RST_NUM(0)) dutNoSw_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdNoSw), .idValid(idValid), .idOp(idOp), .idCode(idCode), .idAck(ackNoSw),
    .idError(errNoSw), .idStatus(stNoSw), .periphRst(prNoSw), .sysRstReq(reqNoSw));

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic idIssue(input logic [1:0] op, input logic [15:0] code,
                         output logic ack, output logic err, output logic st);
    @(negedge clk);
    idOp = op; idCode = code; idValid = 1'b1;
    #1 ack = idAck; err = idError; st = idStatus;
    @(negedge clk);
    idValid = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] d;
    busRead(8'h20, d); check("R1 reg20", d, 0);
    busRead(8'h24, d); check("R1 reg24", d, 0);
    busRead(8'h34, d); check("R1 reg34", d, 0);
    busRead(8'h14, d); check("R1 sw", d, 0);
    check("R1 lines", periphRst, 0);
    check("R1 req", sysRstReq, 0);
  endtask

  task automatic tBusWrite();
    logic [31:0] d;
    busWrite(8'h20, 32'hA5A5_0001);
    busWrite(8'h24, 32'h1234_5678);
    busWrite(8'h34, 32'hDEAD_BEEF);
    busRead(8'h20, d); check("R2 rd20", d, 32'hA5A5_0001);
    busRead(8'h24, d); check("R2 rd24", d, 32'h1234_5678);
    busRead(8'h34, d); check("R2 rd34", d, 32'hDEAD_BEEF);
    check("R2 lines", periphRst, {32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_0001});
  endtask

  task automatic tUnmapped();
    logic [31:0] d;
    busWrite(8'h28, 32'hFFFF_FFFF);
    busRead(8'h28, d); check("R3 rd28", d, 0);
    check("R3 lines", periphRst, {32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_0001});
  endtask

  task automatic tSetClr();
    logic a, e, s;
    logic [31:0] d;
    idIssue(2'b00, 16'h2407, a, e, s);
    check("R4 ack/err", {a, e}, 2'b10);
    busRead(8'h24, d); check("R4 set", d, 32'h1234_56F8);
    check("R4 line39", periphRst[39], 1);
    idIssue(2'b01, 16'h3400, a, e, s);
    check("R5 ack/err", {a, e}, 2'b10);
    busRead(8'h34, d); check("R5 clr34", d, 32'hDEAD_BEEE);
    idIssue(2'b01, 16'h201F, a, e, s);
    busRead(8'h20, d); check("R5 clr20", d, 32'h25A5_0001);
  endtask

  task automatic tStatus();
    logic a, e, s;
    idIssue(2'b10, 16'h3401, a, e, s);
    check("R6 one", {a, e, s}, 3'b101);
    idIssue(2'b10, 16'h3404, a, e, s);
    check("R6 zero", {a, e, s}, 3'b100);
    check("R6 unchanged", periphRst, {32'hDEAD_BEEE, 32'h1234_56F8, 32'h25A5_0001});
  endtask

  task automatic tIllegal();
    logic a, e, s;
    idIssue(2'b00, 16'h1405, a, e, s);
    check("R7 bad offset", {a, e, s}, 3'b110);
    check("R7 no req", sysRstReq, 0);
    idIssue(2'b01, 16'h2020, a, e, s);
    check("R7 bit32", {a, e, s}, 3'b110);
    idIssue(2'b11, 16'h2000, a, e, s);
    check("R7 bad op", {a, e, s}, 3'b110);
    check("R7 unchanged", periphRst, {32'hDEAD_BEEE, 32'h1234_56F8, 32'h25A5_0001});
  endtask

  task automatic tStall();
    logic [31:0] d;
    @(negedge clk);
    busAddr = 8'h20; busWrData = 32'h0000_00F0; busWrEn = 1'b1;
    idOp = 2'b01; idCode = 16'h2004; idValid = 1'b1;
    #1 check("R8 stalled ack", idAck, 0);
    @(negedge clk);
    busWrEn = 1'b0;
    #1 check("R8 later ack", idAck, 1);
    @(negedge clk);
    idValid = 1'b0;
    busRead(8'h20, d); check("R8 order", d, 32'h0000_00E0);
  endtask

  task automatic tSwReset();
    logic [31:0] d;
    busWrite(8'h14, 32'h0000_0004);
    check("R9 no req", sysRstReq, 0);
    busRead(8'h14, d); check("R9 held", d, 32'h4);
    busWrite(8'h14, 32'h0000_0020);
    check("R9 pulse", sysRstReq, 1);
    check("R10 none", reqNoSw, 0);
    @(negedge clk);
    check("R9 pulse end", sysRstReq, 0);
    busRead(8'h14, d); check("R9 cleared", d, 0);
    check("R10 none later", reqNoSw, 0);
    #1 check("R10 not cleared", rdNoSw, 32'h20);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBusWrite();
    tUnmapped();
    tSetClr();
    tStatus();
    tIllegal();
    tStall();
    tSwReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule